// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers the event sources of a real-time clock and turns them into one interrupt request. Three standard sources (periodic tick, alarm match, update-ended) and three extended sources (memory-clear done, wake-up alarm, kickstart) each arrive as a one-cycle pulse. Every pulse latches a status flag whether or not the source is enabled. A per-source enable, supplied by the control register that owns it, decides whether a latched flag takes part in the interrupt.

The standard flags are presented in a status byte whose top bit summarises the enabled, pending sources. The host clears the standard flags by reading that byte, and clears the extended flags by writing zeros to them. A second status byte carries only the battery-valid indication. The interrupt line is the same summary as the top status bit.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every flag is 0, `irq` is 0, and `stat_c`, `stat_ext` read 0x00.
- R2: A pulse on `evt_std[2]`, `evt_std[1]` or `evt_std[0]` (periodic, alarm, update-ended) sets `stat_c` bit 6, 5 or 4 respectively at the next clock edge, whatever the enables are.
- R3: A pulse on `evt_ext[2]`, `evt_ext[1]` or `evt_ext[0]` (memory-clear, wake-up, kickstart) sets `stat_ext` bit 2, 1 or 0 respectively at the next clock edge, whatever the enables are.
- R4: `irq` and `stat_c` bit 7 are 1 exactly when some standard flag and its bit of `en_std` are both 1, or some extended flag and the bit of `en_ext` at the same position are both 1; both follow enable changes in the same cycle.
- R5: `stat_c` bits 3:0 and `stat_ext` bits 7:3 always read 0.
- R6: While `c_rd` is high, `stat_c` shows the current flags; at that clock edge standard flags 6:4 clear, and the extended flags are left as they were.
- R7: When `ext_wr` is high, each extended flag whose `ext_wdata` bit is 0 clears at that edge; a bit written 1 leaves its flag unchanged.
- R8: An event pulse arriving in the same cycle as a clearing read or clearing write leaves its flag set.
- R9: `stat_d` bit 7 equals `ram_valid` and bits 6:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_std | input | 3 | Standard event pulses: [2] periodic, [1] alarm, [0] update-ended |
| evt_ext | input | 3 | Extended event pulses: [2] memory-clear, [1] wake-up, [0] kickstart |
| en_std | input | 3 | Standard enables, same order as `evt_std` |
| en_ext | input | 3 | Extended enables, same order as `evt_ext` |
| ram_valid | input | 1 | Battery-valid indication shown in `stat_d` bit 7 |
| c_rd | input | 1 | Clearing-read strobe of the standard status byte |
| ext_wr | input | 1 | Write strobe of the extended flags |
| ext_wdata | input | 3 | Write data for the extended flags; 0 clears |
| stat_c | output | 8 | Standard status: [7] summary, [6:4] flags, [3:0] zero |
| stat_d | output | 8 | Valid status: [7] valid, [6:0] zero |
| stat_ext | output | 8 | Extended status: [2:0] flags, [7:3] zero |
| irq | output | 1 | Active-high interrupt request |

## Verification
Directed phases first pulse each source alone with all enables off, which separates flag latching from interrupt gating and pins every source to its bit. Enables are then walked one at a time against set flags, which tells a correct pairing from a crossed one. Clearing reads and writes are issued with and without a coincident event, and with mixed one/zero write data, to separate clear-wins from set-wins and clear-on-zero from clear-on-one. A long stretch of random pulses, enables and strobes is finally compared every cycle against a behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_N = 3;            // sources per register set
  localparam int BYTE_W = 8;
  localparam int STD_LSB = 4;          // first standard flag bit in the status byte
  localparam int SUM_BIT = 7;          // summary bit position
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic         upd;

  // set wins over clear, per bit
  always_comb begin
    upd = (|evt) | (|clr);
    for (int i = 0; i < N; i++) begin
      flags_d[i] = evt[i] | (flags_q[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt))); // R8
  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> ((flags & ~$past(flags)) == '0)); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr != '0) && (evt == '0)) |=> ((flags & $past(clr)) == '0)); // R7
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary #(
  parameter int N = 3
) (
  input  logic [N-1:0] std_flags,
  input  logic [N-1:0] std_en,
  input  logic [N-1:0] ext_flags,
  input  logic [N-1:0] ext_en,
  output logic         req
);
  logic [2*N-1:0] armed;

  generate
    for (genvar g = 0; g < N; g++) begin : g_pair
      assign armed[g]     = std_flags[g] & std_en[g];
      assign armed[N + g] = ext_flags[g] & ext_en[g];
    end
  endgenerate

  assign req = |armed;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_std,
  input  logic [SRC_N-1:0] evt_ext,
  input  logic [SRC_N-1:0] en_std,
  input  logic [SRC_N-1:0] en_ext,
  input  logic             ram_valid,
  input  logic             c_rd,
  input  logic             ext_wr,
  input  logic [SRC_N-1:0] ext_wdata,
  output logic [7:0]       stat_c,
  output logic [7:0]       stat_d,
  output logic [7:0]       stat_ext,
  output logic             irq
);
  localparam int STD_TOP = STD_LSB + SRC_N - 1;

  // reset: asserted asynchronously, released after two edges
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  src_vec_t std_flags;
  src_vec_t ext_flags;
  src_vec_t std_clr;
  src_vec_t ext_clr;
  logic     req;

  always_comb begin
    std_clr = {SRC_N{c_rd}};
    ext_clr = {SRC_N{ext_wr}} & ~ext_wdata;
  end

  irqc_flag_bank #(.N(SRC_N)) i_std_bank (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .evt   (evt_std),
    .clr   (std_clr),
    .flags (std_flags)
  );

  irqc_flag_bank #(.N(SRC_N)) i_ext_bank (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .evt   (evt_ext),
    .clr   (ext_clr),
    .flags (ext_flags)
  );

  irqc_summary #(.N(SRC_N)) i_summary (
    .std_flags (std_flags),
    .std_en    (en_std),
    .ext_flags (ext_flags),
    .ext_en    (en_ext),
    .req       (req)
  );

  always_comb begin
    stat_c                   = '0;
    stat_c[SUM_BIT]          = req;
    stat_c[STD_TOP:STD_LSB]  = std_flags;
    stat_ext                 = '0;
    stat_ext[SRC_N-1:0]      = ext_flags;
    stat_d                   = '0;
    stat_d[BYTE_W-1]         = ram_valid;
  end

  assign irq = req;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (c_rd && (evt_std == '0)) |=> (stat_c[STD_TOP:STD_LSB] == '0)); // R6
  AST_READ_KEEPS_EXT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (c_rd && !ext_wr) |=> ((stat_ext[SRC_N-1:0] & $past(stat_ext[SRC_N-1:0])) == $past(stat_ext[SRC_N-1:0]))); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ((stat_c[STD_TOP:STD_LSB] == '0) && (stat_ext[SRC_N-1:0] == '0)) |-> !irq); // R4
  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ext_wr && (ext_wdata == '1)) |=> ((stat_ext[SRC_N-1:0] & $past(stat_ext[SRC_N-1:0])) == $past(stat_ext[SRC_N-1:0]))); // R7
  AST_SUMMARY_IS_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_q)
    stat_c[SUM_BIT] == irq); // R4
endmodule

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] evt_std, evt_ext, en_std, en_ext, ext_wdata;
  logic       ram_valid, c_rd, ext_wr;
  logic [7:0] stat_c, stat_d, stat_ext;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  bit [2:0] m_std, m_ext;

  always #2.5 clk = ~clk;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_std(evt_std), .evt_ext(evt_ext),
    .en_std(en_std), .en_ext(en_ext), .ram_valid(ram_valid), .c_rd(c_rd),
    .ext_wr(ext_wr), .ext_wdata(ext_wdata), .stat_c(stat_c), .stat_d(stat_d),
    .stat_ext(stat_ext), .irq(irq)
  );

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    bit any;
    any = ((m_std & en_std) != 0) || ((m_ext & en_ext) != 0);
    check(tag, "stat_c", stat_c, {any, m_std, 4'b0000});
    check(tag, "stat_ext", stat_ext, {5'b00000, m_ext});
    check(tag, "stat_d", stat_d, {ram_valid, 7'b0000000});
    check(tag, "irq", {7'b0, irq}, {7'b0, any});
  endtask

  // inputs are set at a negedge; outputs are compared 1 ns later; the model
  // advances on the posedge using the same, still stable, inputs
  task automatic step(string tag);
    #1;
    compare(tag);
    @(posedge clk);
    if (c_rd) m_std = 3'b000;
    if (ext_wr) m_ext = m_ext & ext_wdata;
    m_std = m_std | evt_std;
    m_ext = m_ext | evt_ext;
    @(negedge clk);
    evt_std = 0; evt_ext = 0; c_rd = 0; ext_wr = 0; ext_wdata = 3'b111;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt_std = 0; evt_ext = 0; en_std = 0; en_ext = 0;
    ram_valid = 0; c_rd = 0; ext_wr = 0; ext_wdata = 3'b111;
    m_std = 0; m_ext = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    step("R1");

    // R2: each standard source alone, enables off
    for (int i = 0; i < 3; i++) begin
      evt_std = 3'b001 << i; step("R2");
      step("R2");
      c_rd = 1; step("R6");
      step("R6");
    end
    // R3: each extended source alone, enables off
    for (int i = 0; i < 3; i++) begin
      evt_ext = 3'b001 << i; step("R3");
      step("R3");
      ext_wr = 1; ext_wdata = 3'b000; step("R7");
    end
    // R4: walk enables against set flags
    evt_std = 3'b111; evt_ext = 3'b111; step("R4");
    for (int i = 0; i < 3; i++) begin
      en_std = 3'b001 << i; en_ext = 0; step("R4");
      en_std = 0; en_ext = 3'b001 << i; step("R4");
    end
    en_ext = 0;
    // R4: enable on a clear flag gives no request
    c_rd = 1; step("R6");
    en_std = 3'b111; step("R4");
    // R6: read clears standard but keeps extended
    evt_std = 3'b101; step("R6");
    c_rd = 1; step("R6");
    step("R6");
    // R7: mixed write data
    ext_wr = 1; ext_wdata = 3'b101; step("R7");
    ext_wr = 1; ext_wdata = 3'b111; step("R7");
    // R8: coincident events with clears
    evt_std = 3'b010; c_rd = 1; step("R8");
    step("R8");
    evt_ext = 3'b100; ext_wr = 1; ext_wdata = 3'b000; step("R8");
    step("R8");
    // R5 and R9: fixed-zero bits and valid bit
    ram_valid = 1; step("R9");
    ram_valid = 0; step("R5");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      evt_std = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      evt_ext = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      en_std = 3'($urandom_range(0, 7));
      en_ext = 3'($urandom_range(0, 7));
      ram_valid = 1'($urandom_range(0, 1));
      c_rd = ($urandom_range(0, 3) == 0);
      ext_wr = ($urandom_range(0, 3) == 0);
      ext_wdata = 3'($urandom_range(0, 7));
      step("R8");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule